// File: doc/BRIEF.md
# Flash Program/Erase Protection Controller

This block sits between the CPU register bus and an embedded flash array and decides, cycle by cycle, whether the array may be in program mode or erase mode. Software owns a control register (software-enable, program and erase bits) and two byte-wide block-enable registers, one bit per erase block. The block combines that software state with a hardware write-enable pin, the low-power mode the chip is entering, and a set of CPU event strobes. From these it drives the effective program enable, the effective erase enable and a per-block erase mask.

Three layers can each veto an operation. The hardware layer (pin low or a protecting low-power mode) aborts at once and wipes the software registers. The software layer requires the enable bit, rejects a request that sets program and erase together, and masks erasure per block. The runtime layer watches for CPU behaviour that is illegal while the array is busy (a flash read, exception entry, a sleep instruction, loss of bus grant) and latches a sticky error flag that shuts both modes off until reset or hardware standby.

Top module: `flash_prot_ctrl`

## Requirements
- R1: While `wr_en_pin_i` is 0, `prog_en_o`, `erase_en_o` and `blk_erase_o` are 0 in that same cycle, and no mode can start.
- R2: `lp_mode_i` encodes 0 run, 1 sleep, 2 software standby, 3 hardware standby, 4 sub-active, 5 sub-sleep, 6 watch, 7 reserved; any value of 2 or above forces the same protection as R1, while 0 and 1 do not.
- R3: At each clock edge where R1 or R2 protection holds, the control register and both block registers become 0x00; after reset all readable registers are 0x00 and all outputs are 0.
- R4: Register map: address 0 control (bit 7 software-enable, bit 1 erase, bit 0 program, other bits read 0); address 1 status (bit 7 error, others 0); address 2 blocks 0..7; address 3 blocks 8..15. With software-enable 0, no mode is entered whatever the program and erase bits hold.
- R5: When program and erase bits are both 1, neither `prog_en_o` nor `erase_en_o` is asserted.
- R6: `prog_en_o` is 1 exactly when software-enable and program are 1, erase is 0, the error flag is 0 and no hardware protection holds; `erase_en_o` likewise with the two bits swapped. Register writes take effect from the next edge.
- R7: `blk_erase_o` bit n equals block-register bit n (address 2 bits 7..0 give blocks 7..0, address 3 gives 15..8) ANDed with `erase_en_o`; with both block registers 0x00 the mask is 0 even in erase mode.
- R8: If any of `ev_flash_rd_i`, `ev_exc_i`, `ev_sleep_i`, `ev_bus_lost_i` is 1 at a clock edge while `prog_en_o` or `erase_en_o` is 1, the error flag is 1 after that edge and both enables drop to 0.
- R9: An event strobe at an edge where both enables are 0, including a cycle where hardware protection falls in the same cycle, leaves the error flag unchanged.
- R10: The error flag ignores register writes and pin or other low-power protection; it clears only on reset or at an edge with `lp_mode_i` equal to 3.
- R11: While the error flag is 1, rewriting the control register does not bring either enable back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, covers watchdog reset |
| wr_en_pin_i | input | 1 | Hardware write-enable pin, 0 forces protection |
| lp_mode_i | input | 3 | Low-power mode being entered |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for `reg_addr_i` |
| ev_flash_rd_i | input | 1 | CPU read of flash, including vector read and fetch |
| ev_exc_i | input | 1 | Exception entry other than reset |
| ev_sleep_i | input | 1 | Sleep instruction executed |
| ev_bus_lost_i | input | 1 | CPU lost bus grant |
| prog_en_o | output | 1 | Effective program mode |
| erase_en_o | output | 1 | Effective erase mode |
| blk_erase_o | output | 16 | Per-block erase mask |
| err_o | output | 1 | Error protection flag |

## Verification
The interesting collision is a misuse event landing in the same cycle that hardware protection engages: the pin drops or a protecting low-power mode is requested exactly while a flash read or bus loss strobes during an active program. The bench drives that combination deliberately and also lets the random stream hit it, then judges that the enables fall in that very cycle and that the error flag stays clear, because the operation was already aborted by the hardware layer. The other collision, a register write arriving with an event strobe, is judged against a model that lets the pre-edge mode decide whether the error latches.

// File: rtl/flash_prot_pkg.sv
package flash_prot_pkg;
  localparam logic [2:0] LP_SSTBY = 3'd2;  // first mode code that protects
  localparam logic [2:0] LP_HSTBY = 3'd3;

  localparam int unsigned CTL_SWE = 7;
  localparam int unsigned CTL_ERS = 1;
  localparam int unsigned CTL_PRG = 0;
  localparam int unsigned STS_ERR = 7;

  typedef struct packed {
    logic swe;
    logic ers;
    logic prg;
  } ctl_t;
endpackage

// File: rtl/fp_hw_guard.sv
module fp_hw_guard
  import flash_prot_pkg::*;
(
  input  logic       wr_en_pin_i,
  input  logic [2:0] lp_mode_i,
  output logic       hw_prot_o,
  output logic       err_clr_o
);
  always_comb begin
    hw_prot_o = !wr_en_pin_i || (lp_mode_i >= LP_SSTBY);
    err_clr_o = (lp_mode_i == LP_HSTBY);
  end
endmodule

// File: rtl/fp_regs.sv
module fp_regs
  import flash_prot_pkg::*;
#(
  parameter int unsigned REG_W  = 8,
  parameter int unsigned EBR_N  = 2,
  parameter int unsigned ADDR_W = 2,
  localparam int unsigned BLK_N = REG_W * EBR_N
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hw_prot_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic              err_i,
  output ctl_t              ctl_o,
  output logic [BLK_N-1:0]  ebr_o,
  output logic [REG_W-1:0]  rdata_o
);
  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(1);

  ctl_t                         ctl_q;
  logic [EBR_N-1:0][REG_W-1:0]  ebr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
    end else if (hw_prot_i) begin
      ctl_q <= '0;
    end else if (we_i && addr_i == A_CTL) begin
      ctl_q.swe <= wdata_i[CTL_SWE];
      ctl_q.ers <= wdata_i[CTL_ERS];
      ctl_q.prg <= wdata_i[CTL_PRG];
    end
  end

  for (genvar g = 0; g < EBR_N; g++) begin : g_ebr
    localparam logic [ADDR_W-1:0] A_EBR = ADDR_W'(g + 2);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ebr_q[g] <= '0;
      end else if (hw_prot_i) begin
        ebr_q[g] <= '0;
      end else if (we_i && addr_i == A_EBR) begin
        ebr_q[g] <= wdata_i;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_CTL) begin
      rdata_o[CTL_SWE] = ctl_q.swe;
      rdata_o[CTL_ERS] = ctl_q.ers;
      rdata_o[CTL_PRG] = ctl_q.prg;
    end else if (addr_i == A_STS) begin
      rdata_o[STS_ERR] = err_i;
    end else begin
      for (int i = 0; i < EBR_N; i++) begin
        if (addr_i == ADDR_W'(i + 2)) rdata_o = ebr_q[i];
      end
    end
  end

  assign ctl_o = ctl_q;
  assign ebr_o = ebr_q;

  a_r3_hw_wipe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_prot_i |=> (ctl_o == '0) && (ebr_o == '0));
endmodule

// File: rtl/fp_err_det.sv
module fp_err_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busy_i,
  input  logic ev_flash_rd_i,
  input  logic ev_exc_i,
  input  logic ev_sleep_i,
  input  logic ev_bus_lost_i,
  input  logic clr_i,
  output logic err_o
);
  logic any_ev;
  logic err_q;

  assign any_ev = ev_flash_rd_i | ev_exc_i | ev_sleep_i | ev_bus_lost_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q <= 1'b0;
    end else if (clr_i) begin
      err_q <= 1'b0;
    end else if (busy_i && any_ev) begin
      err_q <= 1'b1;
    end
  end

  assign err_o = err_q;

  a_r8_misuse_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && any_ev |=> err_o);
  a_r9_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i && !err_o |=> !err_o);
  a_r10_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o && !clr_i |=> err_o);
endmodule

// File: rtl/fp_mode_gate.sv
module fp_mode_gate
  import flash_prot_pkg::*;
#(
  parameter int unsigned BLK_N = 16
) (
  input  logic             hw_prot_i,
  input  logic             err_i,
  input  ctl_t             ctl_i,
  input  logic [BLK_N-1:0] ebr_i,
  output logic             prog_en_o,
  output logic             erase_en_o,
  output logic [BLK_N-1:0] blk_mask_o
);
  logic allow;

  assign allow      = ctl_i.swe && !err_i && !hw_prot_i;
  assign prog_en_o  = allow && ctl_i.prg && !ctl_i.ers;
  assign erase_en_o = allow && ctl_i.ers && !ctl_i.prg;

  for (genvar b = 0; b < BLK_N; b++) begin : g_blk
    assign blk_mask_o[b] = ebr_i[b] & erase_en_o;
  end
endmodule

// File: rtl/flash_prot_ctrl.sv
module flash_prot_ctrl
  import flash_prot_pkg::*;
#(
  parameter int unsigned REG_W  = 8,
  parameter int unsigned EBR_N  = 2,
  localparam int unsigned BLK_N  = REG_W * EBR_N,
  localparam int unsigned ADDR_W = $clog2(EBR_N + 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_pin_i,
  input  logic [2:0]        lp_mode_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic              ev_flash_rd_i,
  input  logic              ev_exc_i,
  input  logic              ev_sleep_i,
  input  logic              ev_bus_lost_i,
  output logic              prog_en_o,
  output logic              erase_en_o,
  output logic [BLK_N-1:0]  blk_erase_o,
  output logic              err_o
);
  logic             hw_prot;
  logic             err_clr;
  ctl_t             ctl;
  logic [BLK_N-1:0] ebr;
  logic             err;

  fp_hw_guard u_guard (
    .wr_en_pin_i (wr_en_pin_i),
    .lp_mode_i   (lp_mode_i),
    .hw_prot_o   (hw_prot),
    .err_clr_o   (err_clr)
  );

  fp_regs #(.REG_W(REG_W), .EBR_N(EBR_N), .ADDR_W(ADDR_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hw_prot_i (hw_prot),
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .err_i     (err),
    .ctl_o     (ctl),
    .ebr_o     (ebr),
    .rdata_o   (reg_rdata_o)
  );

  fp_err_det u_err (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .busy_i        (prog_en_o | erase_en_o),
    .ev_flash_rd_i (ev_flash_rd_i),
    .ev_exc_i      (ev_exc_i),
    .ev_sleep_i    (ev_sleep_i),
    .ev_bus_lost_i (ev_bus_lost_i),
    .clr_i         (err_clr),
    .err_o         (err)
  );

  fp_mode_gate #(.BLK_N(BLK_N)) u_gate (
    .hw_prot_i  (hw_prot),
    .err_i      (err),
    .ctl_i      (ctl),
    .ebr_i      (ebr),
    .prog_en_o  (prog_en_o),
    .erase_en_o (erase_en_o),
    .blk_mask_o (blk_erase_o)
  );

  assign err_o = err;

  a_r1_pin_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_pin_i |-> !prog_en_o && !erase_en_o && (blk_erase_o == '0));
  a_r2_lp_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lp_mode_i >= LP_SSTBY) |-> !prog_en_o && !erase_en_o);
  a_r4_swe_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl.swe |-> !prog_en_o && !erase_en_o);
  a_r5_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(prog_en_o && erase_en_o));
  a_r7_mask_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !erase_en_o |-> (blk_erase_o == '0));
  a_r11_err_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !prog_en_o && !erase_en_o);
endmodule

// File: tb/sim_flash_prot_ctrl.sv
`timescale 1ns/1ps
module sim_flash_prot_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_pin_i = 1'b1;
  logic [2:0]  lp_mode_i = 3'd0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_addr_i = 2'd0;
  logic [7:0]  reg_wdata_i = 8'h00;
  logic [7:0]  reg_rdata_o;
  logic        ev_flash_rd_i = 1'b0, ev_exc_i = 1'b0, ev_sleep_i = 1'b0, ev_bus_lost_i = 1'b0;
  logic        prog_en_o, erase_en_o, err_o;
  logic [15:0] blk_erase_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // model state
  bit m_swe, m_p, m_e, m_err;
  logic [15:0] m_ebr;

  always #4 clk_i = ~clk_i;

  flash_prot_ctrl u0 (.*);

  function automatic bit f_hw(bit pin, logic [2:0] lp);
    return !pin || (lp >= 3'd2);
  endfunction

  function automatic bit f_prog(bit hw);
    return !hw && !m_err && m_swe && m_p && !m_e;
  endfunction

  function automatic bit f_erase(bit hw);
    return !hw && !m_err && m_swe && m_e && !m_p;
  endfunction

  function automatic logic [7:0] f_rd(logic [1:0] a);
    case (a)
      2'd0: return {m_swe, 5'b0, m_e, m_p};
      2'd1: return {m_err, 7'b0};
      2'd2: return m_ebr[7:0];
      default: return m_ebr[15:8];
    endcase
  endfunction

  function automatic string f_tag(bit pin, logic [2:0] lp);
    if (!pin) return "R1";
    if (lp >= 3'd2) return "R2";
    if (m_err) return "R11";
    if (m_p && m_e) return "R5";
    if (!m_swe) return "R4";
    return "R6";
  endfunction

  task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic step(string tag, bit pin, logic [2:0] lp, bit we, logic [1:0] a,
                      logic [7:0] d, logic [3:0] ev);
    bit hw, ep, ee;
    string t;
    @(negedge clk_i);
    wr_en_pin_i = pin; lp_mode_i = lp; reg_we_i = we; reg_addr_i = a; reg_wdata_i = d;
    {ev_bus_lost_i, ev_sleep_i, ev_exc_i, ev_flash_rd_i} = ev;
    #1;
    hw = f_hw(pin, lp);
    ep = f_prog(hw);
    ee = f_erase(hw);
    t = (tag == "") ? f_tag(pin, lp) : tag;
    chk(t, "prog_en", prog_en_o, ep);
    chk(t, "erase_en", erase_en_o, ee);
    chk((tag == "") ? "R7" : tag, "blk_mask", blk_erase_o, m_ebr & {16{ee}});
    chk((tag == "") ? "R10" : tag, "err", err_o, m_err);
    chk((tag == "") ? "R4" : tag, "rdata", reg_rdata_o, f_rd(a));
    @(posedge clk_i);
    if (lp == 3'd3) m_err = 0;
    else if ((ep || ee) && (ev != 0)) m_err = 1;
    if (hw) begin
      m_swe = 0; m_p = 0; m_e = 0; m_ebr = '0;
    end else if (we) begin
      case (a)
        2'd0: begin m_swe = d[7]; m_e = d[1]; m_p = d[0]; end
        2'd2: m_ebr[7:0] = d;
        2'd3: m_ebr[15:8] = d;
        default: ;
      endcase
    end
  endtask

  task automatic idle(string tag, logic [1:0] a);
    step(tag, 1, 3'd0, 0, a, 8'h00, 4'h0);
  endtask

  initial begin
    void'($urandom(32'h5EED_F1A5));
    m_swe = 0; m_p = 0; m_e = 0; m_err = 0; m_ebr = '0;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    // reset state R3
    for (int a = 0; a < 4; a++) idle("R3", 2'(a));

    // R6 program mode
    step("R6", 1, 0, 1, 0, 8'h81, 0);
    idle("R6", 0);
    // R5 both bits
    step("R5", 1, 0, 1, 0, 8'h83, 0);
    idle("R5", 0);
    // R4 no software enable
    step("R4", 1, 0, 1, 0, 8'h02, 0);
    idle("R4", 0);
    // R7 erase with empty block regs, then a pattern
    step("R7", 1, 0, 1, 0, 8'h82, 0);
    idle("R7", 2);
    step("R7", 1, 0, 1, 2, 8'hA5, 0);
    step("R7", 1, 0, 1, 3, 8'h3C, 0);
    idle("R7", 3);
    // R8 flash read during erase
    step("R8", 1, 0, 0, 1, 8'h00, 4'b0001);
    idle("R8", 1);
    // R11 rewrite control while in error
    step("R11", 1, 0, 1, 0, 8'h81, 0);
    idle("R11", 0);
    // R10 status write and pin protection do not clear the flag
    step("R10", 1, 0, 1, 1, 8'h00, 0);
    step("R10", 0, 0, 0, 1, 8'h00, 0);
    step("R10", 1, 3'd6, 0, 1, 8'h00, 0);
    idle("R10", 1);
    step("R10", 1, 3'd3, 0, 1, 8'h00, 0);
    idle("R10", 1);
    // R8 remaining event kinds, each cleared by hardware standby
    for (int k = 1; k < 4; k++) begin
      step("R8", 1, 0, 1, 0, 8'h81, 0);
      step("R8", 1, 0, 0, 0, 8'h00, 4'(1 << k));
      idle("R8", 1);
      step("R8", 1, 3'd3, 0, 1, 8'h00, 0);
    end
    // R2 protecting and non-protecting modes
    step("R2", 1, 0, 1, 0, 8'h81, 0);
    step("R2", 1, 3'd4, 0, 0, 8'h00, 0);
    idle("R3", 0);
    step("R2", 1, 0, 1, 0, 8'h81, 0);
    step("R2", 1, 3'd1, 0, 0, 8'h00, 0);
    // R1 pin drop aborts, with a flash read in the same cycle (R9)
    step("R1", 0, 0, 0, 0, 8'h00, 4'b0001);
    idle("R9", 1);
    idle("R3", 0);
    // R9 events while idle
    step("R9", 1, 0, 0, 1, 8'h00, 4'b1111);
    idle("R9", 1);
    // R1 write attempt while pin low
    step("R1", 0, 0, 1, 0, 8'h81, 0);
    idle("R1", 0);

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      bit pin, we;
      logic [2:0] lp;
      logic [3:0] ev;
      logic [7:0] d;
      pin = ($urandom_range(0, 19) != 0);
      lp  = ($urandom_range(0, 14) == 0) ? 3'($urandom_range(1, 7)) : 3'd0;
      we  = ($urandom_range(0, 2) == 0);
      ev  = ($urandom_range(0, 9) == 0) ? 4'($urandom_range(1, 15)) : 4'h0;
      d   = 8'($urandom);
      if ($urandom_range(0, 1) == 1) d[7] = 1'b1;
      step("", pin, lp, we, 2'($urandom_range(0, 3)), d, ev);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule